// File: doc/BRIEF.md
# Fault-Aware Fetch-Way Compaction Router

This block sits between instruction fetch and the decode ways of a multi-way superscalar front end. Each cycle, fetch can offer a group of up to `N_WAYS` instruction slots in program order. Slot 0 is the oldest, and each slot has its own valid bit. A runtime fault mask names the decode ways that are disabled. The router packs the pending instructions onto the healthy ways in order. The oldest pending instruction goes to the lowest-numbered healthy way, the next one to the next healthy way, and so on. Each output way carries a valid flag, the instruction word and the slot index it came from, so that decode can confirm program order.

When a group holds more pending instructions than there are healthy ways, the router raises a combinational stall toward fetch. Fetch must then hold the group on its inputs. The router keeps a residue mask of the slots not yet routed and sends them over the following cycles. Stall drops in the cycle that routes the last slot, and fetch offers its next group in the following cycle. A flush discards the residue. If every way is marked faulty, the router moves into a terminal error state and holds stall high.

The controller has three states. In `ST_IDLE` it routes a fresh group taken straight from the inputs. In `ST_DRAIN` it routes the residue of a held group. In `ST_DEAD` all ways are faulty. The transitions are:
- spill: `ST_IDLE` to `ST_DRAIN` when a fresh group leaves a residue.
- drain-continue: `ST_DRAIN` to `ST_DRAIN` while a residue remains.
- drain-done: `ST_DRAIN` to `ST_IDLE` when the residue empties.
- flush: any live state to `ST_IDLE`.
- die: any state to `ST_DEAD` when the mask is all ones.
- revive: `ST_DEAD` to `ST_IDLE` once some way is healthy.

Top module: `fetch_compact_router`

## Requirements
- R1: While reset is applied and just after it is released, with no group offered, no way is valid and both `fetch_stall` and `fatal_err` are low.
- R2: In a cycle that routes a group, `fault_mask` bit i = 1 marks way i faulty, and pending slots are taken in ascending slot order (slot 0 oldest). The k-th pending slot appears on the k-th lowest-numbered healthy way, for k below the healthy-way count. That way carries `way_vld`=1, the slot number on its 2-bit field of `way_slot` (way w uses bits [2w+1:2w]) and that slot's word on bits [32w+31:32w] of `way_instr`. Slots whose `grp_slot_vld` bit is 0 are never routed.
- R3: A way whose fault-mask bit is set never has its `way_vld` bit high.
- R4: When the pending count exceeds the healthy count, `fetch_stall` is high in that same cycle. In each following cycle the next pending slots (at most the healthy count, oldest first) are routed from the held inputs until none remain.
- R5: `fetch_stall` is low in the cycle that routes the last pending slot of a group, including a group with no valid slots. The next cycle treats the inputs as a fresh group.
- R6: In `ST_IDLE` with `grp_valid` low, no way is valid and `fetch_stall` is low, whatever `grp_slot_vld` holds.
- R7: In a cycle with `flush` high, no way is valid. In the next cycle the router is in `ST_IDLE`, any residue is gone, and an offered group is routed again from its oldest slot.
- R8: One cycle after `fault_mask` becomes all ones, `fatal_err` and `fetch_stall` are high and no way is valid. This holds as long as the mask stays all ones. One cycle after some way is healthy again, `fatal_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_valid | input | 1 | Fetch offers a group this cycle |
| grp_slot_vld | input | N_WAYS | Per-slot valid, slot 0 oldest |
| grp_instr | input | N_WAYS*INSTR_W | Slot words, slot s at bits [INSTR_W*s +: INSTR_W] |
| fault_mask | input | N_WAYS | Bit i set marks decode way i faulty |
| flush | input | 1 | Discard the current group and any residue |
| fetch_stall | output | 1 | Combinational: hold the current group |
| fatal_err | output | 1 | Every way is faulty |
| way_vld | output | N_WAYS | Per decode way valid |
| way_instr | output | N_WAYS*INSTR_W | Word routed to each way |
| way_slot | output | N_WAYS*SLOT_W | Source slot index for each way |

## Verification
Routing, `way_vld` and `fetch_stall` all depend combinationally on the registered state and the current inputs. The bench therefore drives each stimulus on the falling edge and checks the results in that same cycle, one time unit later. The effects of residue, flush and the all-faulty mask are carried by the state register, so they are due one rising edge later. The bench checks them on the falling edge after that, one cycle per expected drain step. The bench sweeps every non-fatal fault mask against every slot-valid pattern. A separate walk of the healthy ways against the pending slots predicts, for each drain cycle, which slot lands on which way.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DEAD  = 2'd2
    } fcr_state_t;

endpackage

// File: rtl/fcr_rank.sv
module fcr_rank #(
    parameter int N     = 4,
    parameter int CNT_W = 3
) (
    input  logic [N-1:0]            vec,
    output logic [N-1:0][CNT_W-1:0] rank,
    output logic [CNT_W-1:0]        total
);

    // Prefix count: rank[i] is the number of set bits strictly below i.
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            rank[i] = acc;
            acc     = acc + CNT_W'(vec[i]);
        end
        total = acc;
    end

endmodule

// File: rtl/fcr_way_mux.sv
module fcr_way_mux #(
    parameter int N      = 4,
    parameter int W      = 32,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic                     en,
    input  logic                     healthy,
    input  logic [CNT_W-1:0]         way_rank,
    input  logic [N-1:0]             pending,
    input  logic [N-1:0][CNT_W-1:0]  slot_rank,
    input  logic [N-1:0][W-1:0]      slot_instr,
    output logic                     vld,
    output logic [W-1:0]             out_instr,
    output logic [IDX_W-1:0]         out_slot
);

    logic hit;

    // Pick the pending slot whose order among pending slots equals this
    // way's order among healthy ways; ranks are unique so at most one hits.
    always_comb begin
        hit       = 1'b0;
        out_instr = '0;
        out_slot  = '0;
        for (int s = 0; s < N; s++) begin
            if (pending[s] && (slot_rank[s] == way_rank)) begin
                hit       = 1'b1;
                out_instr = slot_instr[s];
                out_slot  = IDX_W'(s);
            end
        end
        vld = en && healthy && hit;
    end

endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl
    import fcr_pkg::*;
#(
    parameter int N     = 4,
    parameter int CNT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grp_valid,
    input  logic [N-1:0]            slot_vld,
    input  logic [N-1:0]            fault_mask,
    input  logic                    flush,
    input  logic [N-1:0][CNT_W-1:0] slot_rank,
    input  logic [CNT_W-1:0]        pend_cnt,
    input  logic [CNT_W-1:0]        healthy_cnt,
    output logic [N-1:0]            pending,
    output logic                    route_en,
    output logic                    stall,
    output logic                    fatal
);

    fcr_state_t     state, state_nxt;
    logic [N-1:0]   residue, residue_nxt;
    logic [N-1:0]   leftover;
    logic           all_faulty;

    assign all_faulty = &fault_mask;

    // Slots whose pending order falls past the last healthy way stay behind.
    always_comb begin
        for (int s = 0; s < N; s++) begin
            leftover[s] = pending[s] && (slot_rank[s] >= healthy_cnt);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            residue <= '0;
        end else begin
            state   <= state_nxt;
            residue <= residue_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt   = state;
        residue_nxt = residue;
        if (all_faulty) begin
            state_nxt   = ST_DEAD;
            residue_nxt = '0;
        end else if (flush) begin
            state_nxt   = ST_IDLE;
            residue_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (leftover != '0) begin
                        state_nxt   = ST_DRAIN;
                        residue_nxt = leftover;
                    end
                end
                ST_DRAIN: begin
                    if (leftover == '0) begin
                        state_nxt   = ST_IDLE;
                        residue_nxt = '0;
                    end else begin
                        residue_nxt = leftover;
                    end
                end
                ST_DEAD: begin
                    state_nxt   = ST_IDLE;
                    residue_nxt = '0;
                end
                default: begin
                    state_nxt   = ST_IDLE;
                    residue_nxt = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pending  = '0;
        route_en = 1'b0;
        stall    = 1'b0;
        fatal    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                pending  = grp_valid ? slot_vld : '0;
                route_en = !flush;
                stall    = !flush && (pend_cnt > healthy_cnt);
            end
            ST_DRAIN: begin
                pending  = residue;
                route_en = !flush;
                stall    = !flush && (pend_cnt > healthy_cnt);
            end
            ST_DEAD: begin
                stall = 1'b1;
                fatal = 1'b1;
            end
            default: begin
                stall = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fetch_compact_router.sv
module fetch_compact_router #(
    parameter int  N_WAYS  = 4,
    parameter int  INSTR_W = 32,
    localparam int SLOT_W  = $clog2(N_WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        grp_valid,
    input  logic [N_WAYS-1:0]           grp_slot_vld,
    input  logic [N_WAYS*INSTR_W-1:0]   grp_instr,
    input  logic [N_WAYS-1:0]           fault_mask,
    input  logic                        flush,
    output logic                        fetch_stall,
    output logic                        fatal_err,
    output logic [N_WAYS-1:0]           way_vld,
    output logic [N_WAYS*INSTR_W-1:0]   way_instr,
    output logic [N_WAYS*SLOT_W-1:0]    way_slot
);

    localparam int CNT_W = $clog2(N_WAYS + 1);

    logic [N_WAYS-1:0][INSTR_W-1:0] slot_word;
    logic [N_WAYS-1:0]              healthy;
    logic [N_WAYS-1:0]              pending;
    logic [N_WAYS-1:0][CNT_W-1:0]   way_rank;
    logic [N_WAYS-1:0][CNT_W-1:0]   slot_rank;
    logic [CNT_W-1:0]               healthy_cnt;
    logic [CNT_W-1:0]               pend_cnt;
    logic                           route_en;

    assign healthy = ~fault_mask;

    fcr_rank #(.N(N_WAYS), .CNT_W(CNT_W)) u_way_rank (
        .vec   (healthy),
        .rank  (way_rank),
        .total (healthy_cnt)
    );

    fcr_rank #(.N(N_WAYS), .CNT_W(CNT_W)) u_slot_rank (
        .vec   (pending),
        .rank  (slot_rank),
        .total (pend_cnt)
    );

    fcr_ctrl #(.N(N_WAYS), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_valid   (grp_valid),
        .slot_vld    (grp_slot_vld),
        .fault_mask  (fault_mask),
        .flush       (flush),
        .slot_rank   (slot_rank),
        .pend_cnt    (pend_cnt),
        .healthy_cnt (healthy_cnt),
        .pending     (pending),
        .route_en    (route_en),
        .stall       (fetch_stall),
        .fatal       (fatal_err)
    );

    for (genvar s = 0; s < N_WAYS; s++) begin : g_unpack
        assign slot_word[s] = grp_instr[s*INSTR_W +: INSTR_W];
    end

    for (genvar w = 0; w < N_WAYS; w++) begin : g_way
        fcr_way_mux #(
            .N     (N_WAYS),
            .W     (INSTR_W),
            .IDX_W (SLOT_W),
            .CNT_W (CNT_W)
        ) u_mux (
            .en         (route_en),
            .healthy    (healthy[w]),
            .way_rank   (way_rank[w]),
            .pending    (pending),
            .slot_rank  (slot_rank),
            .slot_instr (slot_word),
            .vld        (way_vld[w]),
            .out_instr  (way_instr[w*INSTR_W +: INSTR_W]),
            .out_slot   (way_slot[w*SLOT_W +: SLOT_W])
        );
    end

endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
    parameter int N_WAYS = 4,
    parameter int SLOT_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic [N_WAYS-1:0]        fault_mask,
    input logic                     fetch_stall,
    input logic                     fatal_err,
    input logic [N_WAYS-1:0]        way_vld,
    input logic [N_WAYS*SLOT_W-1:0] way_slot
);

    logic order_ok;

    // Slot indices of valid ways must rise strictly with way number.
    always_comb begin
        logic             seen;
        logic [SLOT_W-1:0] last;
        order_ok = 1'b1;
        seen     = 1'b0;
        last     = '0;
        for (int w = 0; w < N_WAYS; w++) begin
            if (way_vld[w]) begin
                if (seen && (way_slot[w*SLOT_W +: SLOT_W] <= last)) order_ok = 1'b0;
                seen = 1'b1;
                last = way_slot[w*SLOT_W +: SLOT_W];
            end
        end
    end

    // R2
    program_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_ok);

    // R3
    no_faulty_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (way_vld & fault_mask) == '0);

    // R4
    drain_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && !fatal_err && !flush && !(&fault_mask))
        |=> (way_vld != '0 || flush || (&fault_mask)));

    // R7
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (way_vld == '0));

    // R7
    flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !(&fault_mask)) |=> !fatal_err);

    // R8
    dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&fault_mask) |=> (fatal_err && fetch_stall));

    // R8
    dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> (fetch_stall && way_vld == '0));

endmodule

bind fetch_compact_router fcr_checker #(
    .N_WAYS (N_WAYS),
    .SLOT_W (SLOT_W)
) u_fcr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fault_mask  (fault_mask),
    .fetch_stall (fetch_stall),
    .fatal_err   (fatal_err),
    .way_vld     (way_vld),
    .way_slot    (way_slot)
);

// File: tb/fetch_compact_router_test.sv
module fetch_compact_router_test;

    localparam int N  = 4;
    localparam int W  = 32;
    localparam int SW = 2;
    localparam int PW = 1 + N * (1 + SW + W);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               grp_valid = 1'b0;
    logic [N-1:0]       grp_slot_vld = '0;
    logic [N*W-1:0]     grp_instr = '0;
    logic [N-1:0]       fault_mask = '0;
    logic               flush = 1'b0;
    logic               fetch_stall;
    logic               fatal_err;
    logic [N-1:0]       way_vld;
    logic [N*W-1:0]     way_instr;
    logic [N*SW-1:0]    way_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fetch_compact_router #(.N_WAYS(N), .INSTR_W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_valid    (grp_valid),
        .grp_slot_vld (grp_slot_vld),
        .grp_instr    (grp_instr),
        .fault_mask   (fault_mask),
        .flush        (flush),
        .fetch_stall  (fetch_stall),
        .fatal_err    (fatal_err),
        .way_vld      (way_vld),
        .way_instr    (way_instr),
        .way_slot     (way_slot)
    );

    function automatic logic [W-1:0] word_of(input int m, input int p, input int s);
        return 32'h5A00_0000 | W'(m << 12) | W'(p << 8) | W'(s);
    endfunction

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Observed outputs packed as {stall, per way: vld, slot, word}; idle ways read as zero.
    function automatic logic [PW-1:0] observed();
        logic [PW-1:0] v;
        v = '0;
        v[PW-1] = fetch_stall;
        for (int w = 0; w < N; w++) begin
            if (way_vld[w]) begin
                v[w*(1+SW+W) +: (1+SW+W)] = {1'b1, way_slot[w*SW +: SW], way_instr[w*W +: W]};
            end
        end
        return v;
    endfunction

    // Reference: walk healthy ways upward, handing each the next pending slot.
    task automatic predict(input int m, input int p, input logic [N-1:0] pend,
                           output logic [PW-1:0] exp, output logic [N-1:0] rest);
        int s;
        exp  = '0;
        rest = pend;
        s    = 0;
        for (int w = 0; w < N; w++) begin
            if (!m[w]) begin
                while (s < N && !rest[s]) s++;
                if (s < N) begin
                    exp[w*(1+SW+W) +: (1+SW+W)] = {1'b1, SW'(s), word_of(m, p, s)};
                    rest[s] = 1'b0;
                end
            end
        end
        exp[PW-1] = (rest != '0);
    endtask

    task automatic offer(input int m, input int p);
        fault_mask   = N'(m);
        grp_valid    = 1'b1;
        grp_slot_vld = N'(p);
        for (int s = 0; s < N; s++) grp_instr[s*W +: W] = word_of(m, p, s);
    endtask

    task automatic run_group(input int m, input int p);
        logic [N-1:0]  pend;
        logic [N-1:0]  rest;
        logic [PW-1:0] exp;
        int            cyc;
        offer(m, p);
        pend = N'(p);
        cyc  = 0;
        forever begin
            #1;
            predict(m, p, pend, exp, rest);
            chk(cyc == 0 ? "R2 route" : "R4 drain", observed(), exp);
            chk(exp[PW-1] ? "R4 stall" : "R5 release", {{(PW-1){1'b0}}, fetch_stall},
                {{(PW-1){1'b0}}, exp[PW-1]});
            chk("R3 faulty", {{(PW-N){1'b0}}, way_vld & fault_mask}, '0);
            @(negedge clk);
            if (!exp[PW-1]) break;
            pend = rest;
            cyc++;
        end
        grp_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] exp;
        logic [N-1:0]  rest;

        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        chk("R1 in reset", {observed(), fatal_err} , '0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after reset", {observed(), fatal_err}, '0);
        @(negedge clk);

        // R6: no group offered while idle
        fault_mask = '0; grp_slot_vld = 4'b1111; grp_valid = 1'b0;
        #1;
        chk("R6 idle", observed(), '0);
        @(negedge clk);

        // R2 R4 R5: every non-fatal mask against every slot pattern
        for (int m = 0; m < 15; m++) begin
            for (int p = 0; p < 16; p++) begin
                run_group(m, p);
            end
        end

        // R7: flush discards the residue
        offer(4'b1110, 4'b1111);
        #1;
        predict(4'b1110, 4'b1111, 4'b1111, exp, rest);
        chk("R7 pre-flush", observed(), exp);
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk("R7 flush cycle", {{(PW-N){1'b0}}, way_vld}, '0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk("R7 restart from slot 0", observed(), exp);
        chk("R7 no fatal", {{(PW-1){1'b0}}, fatal_err}, '0);
        @(negedge clk);
        grp_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);

        // R8: all ways faulty
        fault_mask = 4'b1111;
        #1;
        chk("R8 not yet fatal", {{(PW-1){1'b0}}, fatal_err}, '0);
        @(negedge clk);
        offer(4'b1111, 4'b0001);
        #1;
        chk("R8 fatal", {{(PW-3){1'b0}}, fatal_err, fetch_stall, way_vld != '0}, {{(PW-3){1'b0}}, 3'b110});
        @(negedge clk);
        #1;
        chk("R8 fatal holds", {{(PW-3){1'b0}}, fatal_err, fetch_stall, way_vld != '0}, {{(PW-3){1'b0}}, 3'b110});
        @(negedge clk);
        fault_mask = '0;
        grp_valid = 1'b0;
        #1;
        chk("R8 still fatal", {{(PW-1){1'b0}}, fatal_err}, {{(PW-1){1'b0}}, 1'b1});
        @(negedge clk);
        offer(0, 1);
        #1;
        chk("R8 revived", {{(PW-1){1'b0}}, fatal_err}, '0);
        predict(0, 1, 4'b0001, exp, rest);
        chk("R8 route after revive", observed(), exp);
        @(negedge clk);
        grp_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule